// File: doc/BRIEF.md
# Reset Strap Latch and Mode Decoder

This block sits at the front of a programmable I/O controller. It settles two things at reset: the operating mode of the controller, and a set of hardware strap values read from pins held by external pull resistors. The mode comes from a dedicated mode pin and the host power-good signal. It is one of three modes: general-purpose, power-management or alternate power-management. Both pins are read while reset is active, and the result is frozen once reset is released.

The same reset window captures an ID word and a 3-bit bus-address select from their pins. Both are held after reset, even when the same pins are later driven as outputs. From the frozen mode the block derives, for each I/O position, whether that position is available as a general I/O, its default direction, and whether it starts in a dedicated function. The top positions of the I/O range are the power-control positions.

A registered global output-enable mask lets only the power-control positions drive while power-good is low or reset is active. All other positions are released one clock after power-good rises.

Top module: `strap_mode_ctrl`

## Requirements
- R1: The mode is 0 (general-purpose) when the mode pin is 0, 1 (power-management) when the mode pin is 1 and power-good is 0, and 2 (alternate power-management) when both are 1; code 3 never appears.
- R2: Mode, ID and address are loaded at every rising clock edge with reset low; after reset is released they keep the values from the last such edge, whatever the pins do.
- R3: The ID output equals the ID pin levels sampled at the last rising edge with reset low and does not follow later changes on those pins.
- R4: The address select sampled during reset passes through unchanged for values 0 to 5; values 6 and 7 produce address code 0.
- R5: In general-purpose mode all 20 I/O positions are marked available; in both power-management modes only positions 0 to 15 are, positions 16 to 19 being power-control.
- R6: Default direction (1 = output): in power-management mode positions 0, 1 and 16 to 19 are outputs; in alternate power-management mode only 16 to 19; in general-purpose mode none. Positions 2, 3 and 4 are inputs in every mode.
- R7: Default function (1 = dedicated): in power-management mode positions 0 (event), 1 (wake), 15 (button) and 16 to 19 (power control); in alternate power-management mode only 16 to 19; in general-purpose mode none.
- R8: The output-enable mask has bits 16 to 19 always set; bits 0 to 15 are set exactly when power-good was high and reset was inactive at the previous rising edge. With reset active the mask is 0xF0000.
- R9: A new reset replaces the mode, ID and address with fresh samples taken during that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, sampled on the rising edge; opens the strap window |
| mode_pin | input | 1 | Mode select pin level |
| pwr_good | input | 1 | Host power-good level |
| id_pins | input | ID_W | ID strap pin levels |
| addr_sel | input | SEL_W | Bus-address select strap pin levels |
| mode_o | output | 2 | Frozen operating mode code |
| id_o | output | ID_W | Held ID word |
| addr_o | output | SEL_W | Folded bus-address code |
| io_avail_o | output | NUM_IO | Position usable as general I/O |
| dflt_dir_o | output | NUM_IO | Default direction, 1 = output |
| dflt_func_o | output | NUM_IO | Default dedicated function flag |
| oe_mask_o | output | NUM_IO | Global output-enable mask |

## Verification
The bench keeps the default parameters: 20 positions, 4 of them power-control, an 8-bit ID and a 3-bit select with 6 legal addresses. With these values one run covers all three modes, both folded select codes (6 and 7) and the pass-through codes. It also covers the event, wake and button positions next to the input-only positions 2 to 4. Each case strobes reset, then inverts the strap pins and toggles power-good after release. This shows that the frozen values hold and that the mask moves one edge behind power-good.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        OPM_GPIO   = 2'd0,
        OPM_PWR    = 2'd1,
        OPM_ALTPWR = 2'd2
    } opmode_e;

endpackage

// File: rtl/smc_mode_decode.sv
module smc_mode_decode
    import smc_pkg::*;
(
    input  logic    mode_pin,
    input  logic    pwr_good,
    output opmode_e mode
);

    always_comb begin
        if (!mode_pin) begin
            mode = OPM_GPIO;
        end else if (pwr_good) begin
            mode = OPM_ALTPWR;
        end else begin
            mode = OPM_PWR;
        end
    end

endmodule

// File: rtl/smc_addr_fold.sv
module smc_addr_fold #(
    parameter int SEL_W    = 3,
    parameter int NUM_ADDR = 6
) (
    input  logic [SEL_W-1:0] sel,
    output logic [SEL_W-1:0] code
);

    localparam logic [SEL_W-1:0] LIMIT = SEL_W'(NUM_ADDR);

    // Codes at or above the legal count fall back to code zero
    always_comb begin
        code = (sel < LIMIT) ? sel : '0;
    end

endmodule

// File: rtl/smc_io_defaults.sv
module smc_io_defaults
    import smc_pkg::*;
#(
    parameter int NUM_IO   = 20,
    parameter int NUM_PC   = 4,
    parameter int EVT_PIN  = 0,
    parameter int WAKE_PIN = 1,
    parameter int BTN_PIN  = 15
) (
    input  opmode_e           mode,
    output logic [NUM_IO-1:0] avail,
    output logic [NUM_IO-1:0] dir,
    output logic [NUM_IO-1:0] func
);

    localparam int PC_BASE = NUM_IO - NUM_PC;

    logic pwr_only;
    logic any_pwr;

    always_comb begin
        pwr_only = (mode == OPM_PWR);
        any_pwr  = (mode == OPM_PWR) || (mode == OPM_ALTPWR);
    end

    for (genvar i = 0; i < NUM_IO; i++) begin : g_pos
        localparam bit IS_PC  = (i >= PC_BASE);
        localparam bit IS_SIG = (i == EVT_PIN) || (i == WAKE_PIN);
        localparam bit IS_BTN = (i == BTN_PIN);

        if (IS_PC) begin : g_pc
            // Power-control positions leave the general pool in either power mode
            always_comb begin
                avail[i] = !any_pwr;
                dir[i]   = any_pwr;
                func[i]  = any_pwr;
            end
        end else begin : g_gen
            always_comb begin
                avail[i] = 1'b1;
                dir[i]   = IS_SIG && pwr_only;
                func[i]  = (IS_SIG || IS_BTN) && pwr_only;
            end
        end
    end

endmodule

// File: rtl/smc_oe_gate.sv
module smc_oe_gate #(
    parameter int NUM_IO = 20,
    parameter int NUM_PC = 4
) (
    input  logic              drive_en,
    output logic [NUM_IO-1:0] mask
);

    localparam int PC_BASE = NUM_IO - NUM_PC;

    for (genvar i = 0; i < NUM_IO; i++) begin : g_bit
        if (i >= PC_BASE) begin : g_pc
            assign mask[i] = 1'b1;
        end else begin : g_gen
            assign mask[i] = drive_en;
        end
    end

endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
    import smc_pkg::*;
#(
    parameter int NUM_IO   = 20,
    parameter int NUM_PC   = 4,
    parameter int ID_W     = 8,
    parameter int SEL_W    = 3,
    parameter int NUM_ADDR = 6,
    parameter int EVT_PIN  = 0,
    parameter int WAKE_PIN = 1,
    parameter int BTN_PIN  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pin,
    input  logic              pwr_good,
    input  logic [ID_W-1:0]   id_pins,
    input  logic [SEL_W-1:0]  addr_sel,
    output logic [1:0]        mode_o,
    output logic [ID_W-1:0]   id_o,
    output logic [SEL_W-1:0]  addr_o,
    output logic [NUM_IO-1:0] io_avail_o,
    output logic [NUM_IO-1:0] dflt_dir_o,
    output logic [NUM_IO-1:0] dflt_func_o,
    output logic [NUM_IO-1:0] oe_mask_o
);

    typedef struct packed {
        opmode_e              mode;
        logic [ID_W-1:0]      id;
        logic [SEL_W-1:0]     addr;
        logic [NUM_IO-1:0]    oe;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    opmode_e           mode_live;
    logic [SEL_W-1:0]  addr_live;
    logic [NUM_IO-1:0] oe_live;

    smc_mode_decode u_mode (
        .mode_pin (mode_pin),
        .pwr_good (pwr_good),
        .mode     (mode_live)
    );

    smc_addr_fold #(
        .SEL_W    (SEL_W),
        .NUM_ADDR (NUM_ADDR)
    ) u_addr (
        .sel  (addr_sel),
        .code (addr_live)
    );

    // Reset counts as power not yet good for the drive mask
    smc_oe_gate #(
        .NUM_IO (NUM_IO),
        .NUM_PC (NUM_PC)
    ) u_oe (
        .drive_en (rst_n & pwr_good),
        .mask     (oe_live)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = oe_live;
        if (!rst_n) begin
            // Strap window: reload every edge while reset is held
            st_d.mode = mode_live;
            st_d.id   = id_pins;
            st_d.addr = addr_live;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    smc_io_defaults #(
        .NUM_IO   (NUM_IO),
        .NUM_PC   (NUM_PC),
        .EVT_PIN  (EVT_PIN),
        .WAKE_PIN (WAKE_PIN),
        .BTN_PIN  (BTN_PIN)
    ) u_dflt (
        .mode  (st_q.mode),
        .avail (io_avail_o),
        .dir   (dflt_dir_o),
        .func  (dflt_func_o)
    );

    assign mode_o    = st_q.mode;
    assign id_o      = st_q.id;
    assign addr_o    = st_q.addr;
    assign oe_mask_o = st_q.oe;

endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
    parameter int NUM_IO   = 20,
    parameter int NUM_PC   = 4,
    parameter int ID_W     = 8,
    parameter int SEL_W    = 3,
    parameter int NUM_ADDR = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_good,
    input logic [1:0]        mode_o,
    input logic [ID_W-1:0]   id_o,
    input logic [SEL_W-1:0]  addr_o,
    input logic [NUM_IO-1:0] io_avail_o,
    input logic [NUM_IO-1:0] oe_mask_o
);

    localparam int PC_BASE = NUM_IO - NUM_PC;

    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_o));

    assert_id_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(id_o));

    assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(addr_o) < NUM_ADDR);

    assert_avail_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(io_avail_o) == NUM_IO) || ($countones(io_avail_o) == PC_BASE));

    assert_oe_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (oe_mask_o[PC_BASE-1:0] == '0));

    assert_pc_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        &oe_mask_o[NUM_IO-1:PC_BASE]);

endmodule

bind strap_mode_ctrl smc_checker #(
    .NUM_IO   (NUM_IO),
    .NUM_PC   (NUM_PC),
    .ID_W     (ID_W),
    .SEL_W    (SEL_W),
    .NUM_ADDR (NUM_ADDR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .mode_o     (mode_o),
    .id_o       (id_o),
    .addr_o     (addr_o),
    .io_avail_o (io_avail_o),
    .oe_mask_o  (oe_mask_o)
);

// File: tb/strap_mode_ctrl_tb.sv
module strap_mode_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_pin = 1'b0;
    logic        pwr_good = 1'b0;
    logic [7:0]  id_pins = '0;
    logic [2:0]  addr_sel = '0;
    logic [1:0]  mode_o;
    logic [7:0]  id_o;
    logic [2:0]  addr_o;
    logic [19:0] io_avail_o;
    logic [19:0] dflt_dir_o;
    logic [19:0] dflt_func_o;
    logic [19:0] oe_mask_o;

    always #5 clk = ~clk;

    strap_mode_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_pin    (mode_pin),
        .pwr_good    (pwr_good),
        .id_pins     (id_pins),
        .addr_sel    (addr_sel),
        .mode_o      (mode_o),
        .id_o        (id_o),
        .addr_o      (addr_o),
        .io_avail_o  (io_avail_o),
        .dflt_dir_o  (dflt_dir_o),
        .dflt_func_o (dflt_func_o),
        .oe_mask_o   (oe_mask_o)
    );

    typedef struct {
        string       tag;
        logic [1:0]  mode;
        logic [7:0]  id;
        logic [2:0]  addr;
        logic [19:0] avail;
        logic [19:0] dir;
        logic [19:0] func;
        logic [19:0] oe;
    } exp_t;

    exp_t sbq[$];
    event push_ev;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    function automatic logic [1:0] m_mode(bit mp, bit pg);
        if (!mp) return 2'd0;
        return pg ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [2:0] m_addr(logic [2:0] s);
        return (s < 3'd6) ? s : 3'd0;
    endfunction

    function automatic logic [19:0] m_avail(logic [1:0] m);
        return (m == 2'd0) ? 20'hFFFFF : 20'h0FFFF;
    endfunction

    function automatic logic [19:0] m_dir(logic [1:0] m);
        case (m)
            2'd1:    return 20'hF0003;
            2'd2:    return 20'hF0000;
            default: return 20'h00000;
        endcase
    endfunction

    function automatic logic [19:0] m_func(logic [1:0] m);
        case (m)
            2'd1:    return 20'hF8003;
            2'd2:    return 20'hF0000;
            default: return 20'h00000;
        endcase
    endfunction

    task automatic cmp(string req, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s [%s]: actual=%h expected=%h", req, tag, act, exp);
        end
    endtask

    task automatic push(string tag, logic [1:0] m, logic [7:0] id, logic [2:0] a, bit oe_en);
        exp_t e;
        e.tag   = tag;
        e.mode  = m;
        e.id    = id;
        e.addr  = a;
        e.avail = m_avail(m);
        e.dir   = m_dir(m);
        e.func  = m_func(m);
        e.oe    = oe_en ? 20'hFFFFF : 20'hF0000;
        sbq.push_back(e);
        ->push_ev;
    endtask

    // Monitor: compares queued expectations against the ports
    initial begin
        forever begin
            @(push_ev);
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                cmp("R1 R2 mode", e.tag, 32'(mode_o), 32'(e.mode));
                cmp("R3 id", e.tag, 32'(id_o), 32'(e.id));
                cmp("R4 addr", e.tag, 32'(addr_o), 32'(e.addr));
                cmp("R5 avail", e.tag, 32'(io_avail_o), 32'(e.avail));
                cmp("R6 dir", e.tag, 32'(dflt_dir_o), 32'(e.dir));
                cmp("R7 func", e.tag, 32'(dflt_func_o), 32'(e.func));
                cmp("R8 oe", e.tag, 32'(oe_mask_o), 32'(e.oe));
            end
        end
    end

    // Driver: one reset window, release, then disturb pins and power-good
    task automatic run_case(string tag, bit mp, bit pg, logic [7:0] id, logic [2:0] sel);
        logic [1:0] em;
        em = m_mode(mp, pg);
        @(negedge clk);
        rst_n    = 1'b0;
        mode_pin = mp;
        pwr_good = pg;
        id_pins  = id;
        addr_sel = sel;
        @(posedge clk);
        @(negedge clk);
        push({tag, " in-reset R9"}, em, id, m_addr(sel), 1'b0);
        @(posedge clk);
        @(negedge clk);
        rst_n    = 1'b1;
        mode_pin = !mp;
        id_pins  = ~id;
        addr_sel = sel ^ 3'b101;
        @(posedge clk);
        @(negedge clk);
        push({tag, " released"}, em, id, m_addr(sel), pg);
        pwr_good = !pg;
        mode_pin = mp;
        id_pins  = id ^ 8'h5A;
        @(posedge clk);
        @(negedge clk);
        push({tag, " pg-flip"}, em, id, m_addr(sel), !pg);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        run_case("pm sel3", 1'b1, 1'b0, 8'hA5, 3'd3);
        run_case("alt sel5", 1'b1, 1'b1, 8'h3C, 3'd5);
        run_case("gp sel6 fold", 1'b0, 1'b0, 8'h00, 3'd6);
        run_case("gp sel7 fold", 1'b0, 1'b1, 8'hFF, 3'd7);
        run_case("pm sel0", 1'b1, 1'b0, 8'h81, 3'd0);
        run_case("alt sel4", 1'b1, 1'b1, 8'h7E, 3'd4);
        run_case("gp sel1", 1'b0, 1'b0, 8'h12, 3'd1);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule